// File: doc/BRIEF.md
# Reciprocal Square Root Seed Unit

This block accepts one single-precision floating-point operand per handshake and returns a rough estimate of its reciprocal square root. Software or a downstream iteration stage can refine that estimate. For ordinary positive inputs the estimate uses two parts. The exponent comes from a subtraction on the input exponent. The significand is an 8-bit value read from a 128-entry ROM. The ROM index combines the lowest bit of the biased exponent minus one with the six leading fraction bits. The ROM is supplied as an elaboration-time parameter holding 64 pair values. Each odd entry is one less than the even entry before it.

Special operands take fixed results. A NaN of either sign, a zero, a denormal, a negative number and positive infinity each map to a defined word. Two flags come out with every result. The summary flag describes that result alone. The invalid flag is sticky and is cleared only by reset.

The input side is a valid/ready pair. Each accepted operand produces exactly one registered result on the following clock, and that result stays on the outputs until the consumer takes it.

Top module: `rsqrt_seed`

## Requirements
- R1: An input with exponent field 0xFF and a non-zero fraction (a NaN of either sign) yields 0x7FC00000.
- R2: An input with exponent field 0 (zero or denormal) yields infinity carrying the input sign: 0x7F800000 for sign 0, 0xFF800000 for sign 1.
- R3: Any other input with sign bit 1 yields 0x7FC00004. This covers negative normal numbers and negative infinity.
- R4: Positive infinity (0x7F800000) yields 0x00000000.
- R5: For a positive normal input with biased exponent E, the result has sign 0 and exponent field 0xBD − ((E−1) >> 1). For example, 1.0 yields 0x3F7E8000, 2.0 yields 0x3F338000 and 4.0 yields 0x3EFE8000.
- R6: For a positive normal input, result bits [22:15] hold ROM entry ((E−1) & 1)·64 + fraction bits [22:17], and result bits [14:0] are zero. In the default ROM, entry 2k is the k-th pair value and entry 2k+1 is that value minus one. The pair values fall from 253 at index 0 to 3 at index 63.
- R7: The summary flag, presented with each result, is 1 exactly when the operand was a signaling NaN (exponent 0xFF, fraction non-zero, fraction bit 22 clear) or the result is 0x7FC00004. Otherwise it is 0.
- R8: The invalid flag becomes 1 together with the first result whose summary flag is 1. It then stays 1 until reset.
- R9: in_ready is high whenever out_valid is low or out_ready is high. An operand accepted on a clock edge appears with out_valid high after exactly that edge, and out_valid falls after a transfer unless a new operand was accepted on the same edge.
- R10: While out_valid is high and out_ready is low, out_valid, out_data and out_summary do not change.
- R11: After reset, out_valid, out_summary and out_invalid are 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Block can take an operand this cycle |
| in_data | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Reciprocal square root estimate |
| out_summary | output | 1 | Exception summary for the presented result |
| out_invalid | output | 1 | Sticky invalid-operation flag |

## Verification
Directed operands run first: 1.0, 2.0 and 4.0, the smallest and largest normals, and fractions that reach both ends of the ROM. Together these separate the even and odd exponent halves of the table and expose any error in the exponent halving. Signed zeros and denormals, both infinities, quiet and signaling NaNs of each sign, and negative normals follow. They are ordered so that the sticky flag must stay low until the first signaling NaN and must then hold through later clean results. A randomized phase then mixes all operand classes under irregular valid and ready patterns, which tests result holding, back-to-back transfers and the ready rule.

// File: rtl/rsqrt_seed_pkg.sv
package rsqrt_seed_pkg;

  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int SEED_W = 8;
  localparam int IDX_W  = 7;
  localparam int PAIRS  = 2 ** (IDX_W - 1);
  localparam int EXP_BASE = 189;

  typedef enum logic [2:0] {
    K_NAN,
    K_ZERO,
    K_NEG,
    K_PINF,
    K_NORM
  } kind_e;

  // Even-entry values of the seed ROM; each odd entry is one below its even partner.
  localparam logic [SEED_W-1:0] SEED_PAIR_DEF [PAIRS] = '{
    8'd253, 8'd245, 8'd239, 8'd231, 8'd225, 8'd217, 8'd211, 8'd205,
    8'd201, 8'd195, 8'd189, 8'd185, 8'd179, 8'd175, 8'd169, 8'd165,
    8'd161, 8'd157, 8'd153, 8'd149, 8'd145, 8'd141, 8'd137, 8'd133,
    8'd131, 8'd127, 8'd123, 8'd121, 8'd117, 8'd115, 8'd111, 8'd109,
    8'd103, 8'd99,  8'd93,  8'd89,  8'd83,  8'd79,  8'd75,  8'd71,
    8'd67,  8'd63,  8'd59,  8'd55,  8'd53,  8'd49,  8'd45,  8'd43,
    8'd39,  8'd37,  8'd33,  8'd31,  8'd27,  8'd25,  8'd23,  8'd19,
    8'd17,  8'd15,  8'd13,  8'd11,  8'd9,   8'd7,   8'd5,   8'd3
  };

endpackage

// File: rtl/rsqrt_seed_classify.sv
module rsqrt_seed_classify
  import rsqrt_seed_pkg::*;
#(
  parameter int EXP_W_P = EXP_W,
  parameter int MAN_W_P = MAN_W
) (
  input  logic [EXP_W_P+MAN_W_P:0] op,
  output kind_e                    kind,
  output logic                     snan
);

  localparam int TOP = EXP_W_P + MAN_W_P;

  logic               sign;
  logic [EXP_W_P-1:0] expo;
  logic [MAN_W_P-1:0] frac;
  logic               exp_ones;
  logic               exp_zero;
  logic               frac_zero;

  assign sign      = op[TOP];
  assign expo      = op[TOP-1:MAN_W_P];
  assign frac      = op[MAN_W_P-1:0];
  assign exp_ones  = &expo;
  assign exp_zero  = ~|expo;
  assign frac_zero = ~|frac;

  always_comb begin
    if (exp_ones && !frac_zero)      kind = K_NAN;
    else if (exp_zero)               kind = K_ZERO;
    else if (sign)                   kind = K_NEG;
    else if (exp_ones)               kind = K_PINF;
    else                             kind = K_NORM;
  end

  assign snan = exp_ones && !frac_zero && !frac[MAN_W_P-1];

endmodule

// File: rtl/rsqrt_seed_rom.sv
module rsqrt_seed_rom
  import rsqrt_seed_pkg::*;
#(
  parameter int SEED_W_P = SEED_W,
  parameter int IDX_W_P  = IDX_W,
  parameter logic [SEED_W_P-1:0] PAIR_VALS [2**(IDX_W_P-1)] = SEED_PAIR_DEF
) (
  input  logic [IDX_W_P-1:0]  idx,
  output logic [SEED_W_P-1:0] val
);

  localparam int DEPTH = 2 ** IDX_W_P;

  logic [SEED_W_P-1:0] rom_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    if (g % 2 == 0) begin : g_even
      assign rom_q[g] = PAIR_VALS[g/2];
    end else begin : g_odd
      assign rom_q[g] = PAIR_VALS[g/2] - SEED_W_P'(1);
    end
  end

  assign val = rom_q[idx];

endmodule

// File: rtl/rsqrt_seed_assemble.sv
module rsqrt_seed_assemble
  import rsqrt_seed_pkg::*;
#(
  parameter int EXP_W_P    = EXP_W,
  parameter int MAN_W_P    = MAN_W,
  parameter int SEED_W_P   = SEED_W,
  parameter int IDX_W_P    = IDX_W,
  parameter int EXP_BASE_P = EXP_BASE
) (
  input  logic                      sign,
  input  logic [EXP_W_P-1:0]        expo,
  input  logic [IDX_W_P-2:0]        frac_top,
  input  kind_e                     kind,
  input  logic                      snan,
  output logic [IDX_W_P-1:0]        idx,
  input  logic [SEED_W_P-1:0]       seed,
  output logic [EXP_W_P+MAN_W_P:0]  result,
  output logic                      flag
);

  localparam int DATA_W = 1 + EXP_W_P + MAN_W_P;
  localparam int PAD_W  = MAN_W_P - SEED_W_P;
  localparam logic [DATA_W-1:0] QNAN_W =
    {1'b0, {EXP_W_P{1'b1}}, 1'b1, {(MAN_W_P-1){1'b0}}};
  localparam logic [DATA_W-1:0] NEG_NAN_W = QNAN_W | DATA_W'(4);

  logic [EXP_W_P-1:0] exp_m1;
  logic [EXP_W_P-1:0] new_exp;

  assign exp_m1  = expo - EXP_W_P'(1);
  assign idx     = {exp_m1[0], frac_top};
  assign new_exp = EXP_W_P'(EXP_BASE_P) - (exp_m1 >> 1);

  always_comb begin
    unique case (kind)
      K_NAN:   result = QNAN_W;
      K_ZERO:  result = {sign, {EXP_W_P{1'b1}}, {MAN_W_P{1'b0}}};
      K_NEG:   result = NEG_NAN_W;
      K_PINF:  result = '0;
      default: result = {sign, new_exp, seed, {PAD_W{1'b0}}};
    endcase
  end

  assign flag = snan || (kind == K_NEG);

endmodule

// File: rtl/rsqrt_seed.sv
module rsqrt_seed
  import rsqrt_seed_pkg::*;
#(
  parameter int EXP_W_P    = EXP_W,
  parameter int MAN_W_P    = MAN_W,
  parameter int SEED_W_P   = SEED_W,
  parameter int IDX_W_P    = IDX_W,
  parameter int EXP_BASE_P = EXP_BASE,
  parameter logic [SEED_W_P-1:0] PAIR_VALS [2**(IDX_W_P-1)] = SEED_PAIR_DEF
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [EXP_W_P+MAN_W_P:0]  in_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [EXP_W_P+MAN_W_P:0]  out_data,
  output logic                      out_summary,
  output logic                      out_invalid
);

  localparam int DATA_W = 1 + EXP_W_P + MAN_W_P;
  localparam int MBITS  = IDX_W_P - 1;

  kind_e               kind;
  logic                snan;
  logic [IDX_W_P-1:0]  idx;
  logic [SEED_W_P-1:0] seed;
  logic [DATA_W-1:0]   result;
  logic                flag;
  logic                take;

  rsqrt_seed_classify #(.EXP_W_P(EXP_W_P), .MAN_W_P(MAN_W_P)) u_cls (
    .op(in_data), .kind(kind), .snan(snan)
  );

  rsqrt_seed_rom #(
    .SEED_W_P(SEED_W_P), .IDX_W_P(IDX_W_P), .PAIR_VALS(PAIR_VALS)
  ) u_rom (
    .idx(idx), .val(seed)
  );

  rsqrt_seed_assemble #(
    .EXP_W_P(EXP_W_P), .MAN_W_P(MAN_W_P), .SEED_W_P(SEED_W_P),
    .IDX_W_P(IDX_W_P), .EXP_BASE_P(EXP_BASE_P)
  ) u_asm (
    .sign(in_data[DATA_W-1]),
    .expo(in_data[DATA_W-2:MAN_W_P]),
    .frac_top(in_data[MAN_W_P-1 -: MBITS]),
    .kind(kind), .snan(snan), .idx(idx), .seed(seed),
    .result(result), .flag(flag)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_summary <= 1'b0;
      out_invalid <= 1'b0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_data    <= result;
      out_summary <= flag;
      out_invalid <= out_invalid | flag;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/rsqrt_seed_chk.sv
module rsqrt_seed_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_summary,
  input logic              out_invalid
);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_summary));

  a_r9_accept: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  a_r9_drain: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !in_valid |=> !out_valid);

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    out_invalid |=> out_invalid);

  a_r8_summary_sets_invalid: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_summary |-> out_invalid);

  a_r6_low_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_data != 32'h7FC0_0004 |-> out_data[14:0] == 15'd0);

  a_r1_nan: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && (&in_data[30:23]) && (|in_data[22:0])
    |=> out_data == 32'h7FC0_0000);

endmodule

bind rsqrt_seed rsqrt_seed_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_rsqrt_seed.sv
`timescale 1ns/1ps
module sim_rsqrt_seed;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        out_summary;
  logic        out_invalid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rsqrt_seed u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_summary(out_summary), .out_invalid(out_invalid)
  );

  int even_vals [64] = '{
    253, 245, 239, 231, 225, 217, 211, 205, 201, 195, 189, 185, 179, 175, 169, 165,
    161, 157, 153, 149, 145, 141, 137, 133, 131, 127, 123, 121, 117, 115, 111, 109,
    103, 99, 93, 89, 83, 79, 75, 71, 67, 63, 59, 55, 53, 49, 45, 43,
    39, 37, 33, 31, 27, 25, 23, 19, 17, 15, 13, 11, 9, 7, 5, 3
  };

  typedef struct {
    logic [31:0] word;
    bit          flag;
    bit          sticky;
    string       tag;
  } exp_t;

  exp_t        pend[$];
  logic [31:0] stim[$];
  bit          sticky_m = 1'b0;
  bit          prev_stall = 1'b0;
  logic [31:0] prev_data;
  logic        prev_sum;

  function automatic exp_t model(input logic [31:0] x);
    exp_t r;
    int e, m, idx, se, sig;
    e = int'(x[30:23]);
    m = int'(x[22:0]);
    r.flag = 1'b0;
    if (e == 255 && m != 0) begin
      r.word = 32'h7FC0_0000; r.flag = (x[22] == 1'b0); r.tag = "R1";
    end else if (e == 0) begin
      r.word = x[31] ? 32'hFF80_0000 : 32'h7F80_0000; r.tag = "R2";
    end else if (x[31]) begin
      r.word = 32'h7FC0_0004; r.flag = 1'b1; r.tag = "R3";
    end else if (e == 255) begin
      r.word = 32'h0; r.tag = "R4";
    end else begin
      idx = ((e - 1) % 2) * 64 + (m >> 17);
      se  = 189 - (e - 1) / 2;
      sig = even_vals[idx / 2] - (idx % 2);
      r.word = (32'(se) << 23) | (32'(sig) << 15);
      r.tag = "R5_R6";
    end
    r.sticky = 1'b0;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // One bench cycle: drive at the falling edge, observe 1 ns later.
  task automatic cycle(input bit rnd);
    exp_t e;
    @(negedge clk);
    in_valid  = (stim.size() > 0) && (!rnd || ($urandom % 4 != 0));
    in_data   = (stim.size() > 0) ? stim[0] : $urandom;
    out_ready = !rnd || ($urandom % 3 != 0);
    #1;
    check(in_ready === (!out_valid || out_ready), "R9 ready", 32'(in_ready),
          32'(!out_valid || out_ready));
    check(out_valid === (pend.size() > 0), "R9 valid", 32'(out_valid),
          32'(pend.size() > 0));
    if (prev_stall)
      check(out_valid && out_data === prev_data && out_summary === prev_sum,
            "R10 hold", out_data, prev_data);
    if (out_valid && out_ready && pend.size() > 0) begin
      e = pend.pop_front();
      check(out_data === e.word, e.tag, out_data, e.word);
      check(out_summary === e.flag, "R7 summary", 32'(out_summary), 32'(e.flag));
      check(out_invalid === e.sticky, "R8 sticky", 32'(out_invalid), 32'(e.sticky));
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    prev_sum   = out_summary;
    if (in_valid && in_ready) begin
      e = model(stim.pop_front());
      sticky_m = sticky_m | e.flag;
      e.sticky = sticky_m;
      pend.push_back(e);
    end
  endtask

  function automatic logic [31:0] rand_op();
    logic [31:0] v = $urandom;
    case ($urandom % 8)
      0: v[30:23] = 8'hFF;
      1: v[30:23] = 8'h00;
      2: begin v[30:0] = 31'h7F80_0000; end
      default: begin v[31] = ($urandom % 4 == 0); if (v[30:23] == 8'hFF || v[30:23] == 0) v[30:23] = 8'h80; end
    endcase
    return v;
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R11: reset state
    check(out_valid === 1'b0, "R11 out_valid", 32'(out_valid), 0);
    check(out_summary === 1'b0, "R11 out_summary", 32'(out_summary), 0);
    check(out_invalid === 1'b0, "R11 out_invalid", 32'(out_invalid), 0);
    check(in_ready === 1'b1, "R11 in_ready", 32'(in_ready), 1);
    // R5 R6 anchors and table ends, then specials; R8 must stay low until the sNaN
    stim = '{32'h3F80_0000, 32'h4000_0000, 32'h4080_0000, 32'h0080_0000,
             32'h7F7F_FFFF, 32'h3FFE_0000, 32'h407E_0000, 32'h3F81_FFFF,
             32'h0000_0000, 32'h8000_0000, 32'h0000_0001, 32'h807F_FFFF,
             32'h7F80_0000, 32'h7FC0_0000, 32'hFFC0_1234,
             32'h7F80_0001, 32'h3F80_0000, 32'hFF80_0000, 32'hBF80_0000,
             32'hFFA0_0000, 32'h4040_0000};
    while (stim.size() > 0 || pend.size() > 0) cycle(1'b0);
    for (int i = 0; i < 400; i++) stim.push_back(rand_op());
    while (stim.size() > 0 || pend.size() > 0) cycle(1'b1);
    repeat (3) cycle(1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule